// File: doc/BRIEF.md
# Frequency-locked loop integrator

This block is the digital part of a frequency-locked loop that steers a tapped, digitally controlled ring oscillator. The reference clock and the oscillator clock reach it as one-cycle strobes, both synchronous to a single system clock. Each oscillator strobe passes through a selectable pre-divider of 1, 2, 4 or 8 and then through a programmable divide-by-(N+1). A 10-bit up/down integrator counts reference strobes up and divided oscillator strobes down. In lock, the oscillator therefore runs at D·(N+1) times the reference.

The upper five integrator bits select a coarse oscillator tap. Tap codes above 28 are clamped to tap 28. The lower five bits are the fractional modulator value. Over every frame of 32 oscillator periods, the modulator asks for the next higher tap in exactly that many periods, spread as evenly as possible. The integrator value is visible on a read port. A synchronous clear loads it to mid-scale.

The block also drives a clock strobe for the rest of the chip. When the bypass input is low, this strobe is the pre-divided oscillator, at (N+1) times the reference. When the bypass input is high, it is the undivided oscillator, at D·(N+1) times the reference. The intended configuration after reset is bypass low with the pre-divider at 2.

Top module: `fll_integrator`

## Requirements
- R1: During and right after reset, `integ` is 512, `tap` is 16 and `use_next` is 0.
- R2: At every clock edge, `integ` rises by one if only `ref_pulse` is high, and falls by one if only a divided oscillator strobe occurs. It is unchanged when both or neither occur. The change is visible one cycle after the strobe.
- R3: `integ` saturates at 1023 and at 0 and never wraps.
- R4: `div_sel` values 0, 1, 2 and 3 select a pre-divider of 1, 2, 4 and 8. Every D-th `dco_pulse` is a pre-divided strobe. Every (`mult_n`+1)-th pre-divided strobe is a divided strobe that decrements the integrator in that cycle.
- R5: `out_pulse` is combinational. It equals `dco_pulse` when `bypass_prediv` is 1, and the pre-divided strobe when `bypass_prediv` is 0.
- R6: `tap` equals `integ[9:5]`, clamped so that codes 28 to 31 all give 28.
- R7: Oscillator strobes are numbered 1 to 32 within each frame, starting after reset. At strobe 1 the modulator value m = `integ[4:0]` is captured. After strobe k, `use_next` holds floor(k·m/32) − floor((k−1)·m/32) until the next strobe. So over a full frame it is high after exactly m strobes.
- R8: If `mod_off` is 1 at an oscillator strobe, or the tap code `integ[9:5]` is 28 or more at that strobe, `use_next` is 0 for the period that follows.
- R9: `clear` loads 512 into `integ` at the next edge. It takes precedence over both strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous load of the integrator to mid-scale |
| ref_pulse | input | 1 | One-cycle reference clock strobe |
| dco_pulse | input | 1 | One-cycle oscillator clock strobe |
| div_sel | input | 2 | Pre-divider select (1, 2, 4, 8) |
| mult_n | input | 7 | Multiplier N, feedback divide by N+1 |
| bypass_prediv | input | 1 | 1: `out_pulse` is undivided oscillator |
| mod_off | input | 1 | 1: fractional modulator disabled |
| tap | output | 5 | Selected oscillator tap, 0 to 28 |
| use_next | output | 1 | Use the next higher tap for this oscillator period |
| integ | output | 10 | Integrator read port |
| out_pulse | output | 1 | Output clock strobe |

## Verification
Reference-only streams drive the integrator into its upper rail, and undivided oscillator streams drive it into its lower rail. This separates saturation from wrap-around and confirms the tap clamp at the top. Sparse oscillator-only streams at several divider settings count both the integrator decrements and the `out_pulse` strobes, which shows whether the pre-divider and the N+1 stage each divide correctly. Whole frames with a fixed modulator value count the `use_next` periods, first with the modulator on and then with it off. A long random mix of coincident strobes, clears, divider changes and bypass toggles is then compared every cycle against a behavioural model that uses the floor formula for dithering.

// File: rtl/fll_integrator.sv
module fll_integrator #(
  parameter int INT_W   = 10,
  parameter int TAP_W   = 5,
  parameter int N_W     = 7,
  parameter int TAP_MAX = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             ref_pulse,
  input  logic             dco_pulse,
  input  logic [1:0]       div_sel,
  input  logic [N_W-1:0]   mult_n,
  input  logic             bypass_prediv,
  input  logic             mod_off,
  output logic [TAP_W-1:0] tap,
  output logic             use_next,
  output logic [INT_W-1:0] integ,
  output logic             out_pulse
);
  localparam int FRAC_W = INT_W - TAP_W;
  localparam logic [INT_W-1:0] MID = INT_W'(1) << (INT_W - 1);
  localparam logic [INT_W-1:0] TOP = '1;
  localparam logic [TAP_W-1:0] TAP_LIM = TAP_W'(TAP_MAX);

  // divider chain
  logic [2:0]     pre_cnt;
  logic [2:0]     pre_last;
  logic [N_W-1:0] n_cnt;
  logic           pre_tick, fb_tick;

  assign pre_last  = 3'b111 >> (2'd3 - div_sel);
  assign pre_tick  = dco_pulse && (pre_cnt >= pre_last);
  assign fb_tick   = pre_tick && (n_cnt >= mult_n);
  assign out_pulse = bypass_prediv ? dco_pulse : pre_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      n_cnt   <= '0;
    end else if (dco_pulse) begin
      pre_cnt <= pre_tick ? 3'd0 : pre_cnt + 3'd1;
      if (pre_tick) n_cnt <= fb_tick ? '0 : n_cnt + 1'b1;
    end
  end

  // saturating integrator
  logic up, dn;
  assign up = ref_pulse && !fb_tick;
  assign dn = fb_tick && !ref_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    integ <= MID;
    else if (clear)                integ <= MID;
    else if (up && integ != TOP)   integ <= integ + 1'b1;
    else if (dn && integ != '0)    integ <= integ - 1'b1;
  end

  // tap selection
  logic [TAP_W-1:0] code;
  assign code = integ[INT_W-1 -: TAP_W];
  assign tap  = (code > TAP_LIM) ? TAP_LIM : code;

  // fractional modulator
  logic [FRAC_W-1:0] pos, acc, mlat, m_now, acc_now;
  logic [FRAC_W:0]   sum;
  logic              frame_start;

  assign frame_start = (pos == '0);
  assign m_now       = frame_start ? integ[FRAC_W-1:0] : mlat;
  assign acc_now     = frame_start ? '0 : acc;
  assign sum         = {1'b0, acc_now} + {1'b0, m_now};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      acc      <= '0;
      mlat     <= '0;
      use_next <= 1'b0;
    end else if (dco_pulse) begin
      pos      <= pos + 1'b1;
      acc      <= sum[FRAC_W-1:0];
      if (frame_start) mlat <= integ[FRAC_W-1:0];
      use_next <= sum[FRAC_W] && !mod_off && (code < TAP_LIM);
    end
  end
endmodule

// File: rtl/fll_integrator_chk.sv
module fll_integrator_chk #(
  parameter int INT_W   = 10,
  parameter int TAP_W   = 5,
  parameter int TAP_MAX = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             ref_pulse,
  input logic             dco_pulse,
  input logic             bypass_prediv,
  input logic             mod_off,
  input logic [TAP_W-1:0] tap,
  input logic             use_next,
  input logic [INT_W-1:0] integ,
  input logic             out_pulse
);
  localparam logic [INT_W-1:0] MID = INT_W'(1) << (INT_W - 1);
  localparam logic [INT_W-1:0] TOP = '1;
  localparam logic [INT_W-1:0] ONE = INT_W'(1);

  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (integ == $past(integ) || integ == $past(integ) + ONE || integ == $past(integ) - ONE));

  a_r2_ref_up: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pulse && !dco_pulse && !clear && integ != TOP) |=> integ == $past(integ) + ONE);

  a_r3_no_wrap_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (integ == TOP && !clear) |=> integ != '0);

  a_r3_no_wrap_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (integ == '0 && !clear) |=> integ != TOP);

  a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_prediv |-> (out_pulse == dco_pulse));

  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !dco_pulse |-> !out_pulse);

  a_r6_tap_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    tap <= TAP_W'(TAP_MAX));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dco_pulse |=> $stable(use_next));

  a_r8_mod_off: assert property (@(posedge clk) disable iff (!rst_n)
    (dco_pulse && mod_off) |=> !use_next);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> integ == MID);
endmodule

bind fll_integrator fll_integrator_chk #(.INT_W(INT_W), .TAP_W(TAP_W), .TAP_MAX(TAP_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .ref_pulse(ref_pulse), .dco_pulse(dco_pulse),
  .bypass_prediv(bypass_prediv), .mod_off(mod_off), .tap(tap), .use_next(use_next),
  .integ(integ), .out_pulse(out_pulse)
);

// File: tb/sim_fll_integrator.sv
module sim_fll_integrator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0, ref_pulse = 1'b0, dco_pulse = 1'b0;
  logic [1:0] div_sel = 2'd1;
  logic [6:0] mult_n = 7'd0;
  logic bypass_prediv = 1'b0, mod_off = 1'b0;
  logic [4:0] tap;
  logic use_next, out_pulse;
  logic [9:0] integ;

  fll_integrator u0 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .ref_pulse(ref_pulse), .dco_pulse(dco_pulse),
    .div_sel(div_sel), .mult_n(mult_n), .bypass_prediv(bypass_prediv), .mod_off(mod_off),
    .tap(tap), .use_next(use_next), .integ(integ), .out_pulse(out_pulse)
  );

  always #4 clk = ~clk;

  int errs = 0, checks = 0, outs = 0;
  bit done = 0;

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_integ = 512, m_pre = 0, m_n = 0, m_k = 0, m_lat = 0, m_un = 0;

  function automatic int dval(logic [1:0] s);
    return 1 << s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_integ = 512; m_pre = 0; m_n = 0; m_k = 0; m_lat = 0; m_un = 0;
    end else begin
      int fb, m, kk, code;
      fb = 0;
      code = m_integ / 32;
      if (dco_pulse) begin
        if (m_k == 0) m_lat = m_integ % 32;
        m = m_lat;
        kk = m_k + 1;
        if (mod_off || code >= 28) m_un = 0;
        else m_un = (kk * m) / 32 - ((kk - 1) * m) / 32;
        m_k = kk % 32;
        if (m_pre + 1 >= dval(div_sel)) begin
          m_pre = 0;
          if (m_n + 1 >= int'(mult_n) + 1) begin m_n = 0; fb = 1; end
          else m_n++;
        end else m_pre++;
      end
      if (clear) m_integ = 512;
      else begin
        m_integ = m_integ + int'(ref_pulse) - fb;
        if (m_integ > 1023) m_integ = 1023;
        if (m_integ < 0) m_integ = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int et, eo;
      et = (m_integ / 32 > 28) ? 28 : m_integ / 32;
      eo = bypass_prediv ? int'(dco_pulse)
                         : int'(dco_pulse && (m_pre + 1 >= dval(div_sel)));
      chk("R2", int'(integ), m_integ);
      chk("R6", int'(tap), et);
      chk(mod_off ? "R8" : "R7", int'(use_next), m_un);
      chk("R5", int'(out_pulse), eo);
      if (out_pulse) outs++;
    end
  end

  task automatic step(bit r, bit d);
    ref_pulse = r; dco_pulse = d;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    ref_pulse = 0; dco_pulse = 0; clear = 0;
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  initial begin
    #1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(integ), 512);
    chk("R1", int'(tap), 16);
    chk("R1", int'(use_next), 0);
    @(posedge clk); #1 rst_n = 1;

    // R4 / R5: D=2, N=3 -> one decrement per 8 strobes
    div_sel = 2'd1; mult_n = 7'd3; bypass_prediv = 0;
    outs = 0;
    for (int i = 0; i < 80; i++) begin step(0, 1); step(0, 0); end
    @(negedge clk);
    chk("R4", int'(integ), 502);
    chk("R5", outs, 40);

    // R4: D=8, N=0
    do_reset();
    div_sel = 2'd3; mult_n = 7'd0; outs = 0;
    for (int i = 0; i < 80; i++) step(0, 1);
    step(0, 0);
    @(negedge clk);
    chk("R4", int'(integ), 502);
    chk("R5", outs, 10);

    // R5 bypass: every strobe appears
    bypass_prediv = 1; outs = 0;
    for (int i = 0; i < 20; i++) step(0, 1);
    step(0, 0);
    @(negedge clk);
    chk("R5", outs, 20);
    bypass_prediv = 0;

    // R3: top rail
    do_reset();
    for (int i = 0; i < 600; i++) step(1, 0);
    step(0, 0);
    @(negedge clk);
    chk("R3", int'(integ), 1023);
    chk("R6", int'(tap), 28);

    // R2: coincident strobes with D=1, N=0 leave value unchanged
    div_sel = 2'd0; mult_n = 7'd0;
    for (int i = 0; i < 10; i++) step(1, 1);
    step(0, 0);
    @(negedge clk);
    chk("R2", int'(integ), 1023);

    // R3: bottom rail
    for (int i = 0; i < 1100; i++) step(0, 1);
    step(0, 0);
    @(negedge clk);
    chk("R3", int'(integ), 0);

    // R9: clear wins over a reference strobe
    clear = 1; step(1, 0); clear = 0; step(0, 0);
    @(negedge clk);
    chk("R9", int'(integ), 512);

    // R7: modulator value 13 over one full frame
    do_reset();
    for (int i = 0; i < 13; i++) step(1, 0);
    div_sel = 2'd3; mult_n = 7'd127;
    begin
      int cnt;
      cnt = 0;
      dco_pulse = 1;
      @(posedge clk);
      for (int i = 0; i < 32; i++) begin
        @(negedge clk);
        cnt += int'(use_next);
        if (i == 31) dco_pulse = 0;
      end
      chk("R7", cnt, 13);
      // R8: same frame length with modulator disabled
      cnt = 0;
      mod_off = 1;
      dco_pulse = 1;
      @(posedge clk);
      for (int i = 0; i < 32; i++) begin
        @(negedge clk);
        cnt += int'(use_next);
        if (i == 31) dco_pulse = 0;
      end
      chk("R8", cnt, 0);
      mod_off = 0;
    end
    @(posedge clk); #1;

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if (i % 250 == 0) begin
        div_sel = 2'($urandom_range(0, 3));
        mult_n = 7'($urandom_range(0, 5));
      end
      if (i % 97 == 0) mod_off = ~mod_off;
      if (i % 61 == 0) bypass_prediv = ~bypass_prediv;
      clear = ($urandom_range(0, 299) == 0);
      step($urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1);
    end
    clear = 0;
    step(0, 0);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule